// File: doc/BRIEF.md
# Serial Configuration Readback Controller

This block streams stored configuration frames out of a device one bit per rising edge of the configuration clock on a single serial data output. An active-low read-request pin starts a readback with a falling edge. The pin must stay low for the whole operation; raising it stops the stream. The controller reads frames in sequence from a frame memory through a synchronous read port, beginning at a programmable start address. Each frame goes out as a 0-then-1 alignment pair followed by the 32 data bits, so that a receiver can find frame boundaries.

The read-request pin is shared with the global tri-state function. Before configuration completes, the pin always drives the internal tri-state control and readback is blocked. After configuration, a select input decides which of the two functions owns the pin. A two-bit permission option limits readback to never, once, or without limit. Readback through this dedicated path is blocked while the host microprocessor interface is enabled.

Top module: `cfg_readback_ctrl`

## Requirements
- R1: A readback launches only when a low level on `rd_req_n` is sampled on a rising edge whose two preceding rising edges both sampled it high. Call that edge E0. The first alignment bit (0) appears on `sdo` after rising edge E0+LATENCY, where LATENCY defaults to 4. `sdo` stays 1 after edges E0 to E0+LATENCY-1.
- R2: Every frame is sent as 34 consecutive bits, one per rising edge: a 0, then a 1, then the 32-bit frame word with the most significant bit first.
- R3: Frames are sent back to back from `start_frame` up to frame NUM_FRAMES-1 (default 6 frames). After the last data bit of the last frame, `sdo` returns to 1 and stays there.
- R4: A rising edge that samples `rd_req_n` high during a readback stops it. `sdo` is 1 after that edge.
- R5: If `rd_req_n` is held high across at least two rising edges and then driven low, a new readback starts from `start_frame` (frame 0 when `start_frame` is 0). A high level seen on only one rising edge does not start a new readback.
- R6: `perm_opt` 2'b00 and 2'b11 prohibit readback: a request leaves `sdo` at 1.
- R7: `perm_opt` 2'b01 allows a single readback. The use is counted on the edge that emits the first alignment bit. After that, later requests are ignored until reset. A request that is withdrawn before its first alignment bit does not count.
- R8: `perm_opt` 2'b10 allows any number of readbacks.
- R9: While `host_if_en` is 1, readback is blocked. A readback in progress stops, with `sdo` at 1 after the next rising edge.
- R10: `gts_n` (active-low global tri-state) equals `rd_req_n` whenever `cfg_done` is 0, or whenever `pin_sel` is 1; in both cases readback is blocked. When `cfg_done` is 1 and `pin_sel` is 0, `gts_n` is 1 and the pin controls readback.
- R11: For each frame, `mem_rd_en` is 1 for exactly one cycle with `mem_rd_addr` equal to the frame number. This cycle starts at the edge that emits the frame's leading 0. The memory returns the word one edge later, and the controller uses it on the edge after that.
- R12: During and after reset, `sdo` is 1 and `mem_rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock; bits shift on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req_n | input | 1 | Active-low read request, shared with global tri-state |
| cfg_done | input | 1 | 1 once configuration has completed |
| host_if_en | input | 1 | 1 when the host microprocessor interface is enabled |
| perm_opt | input | 2 | Readback permission: 00 none, 01 once, 10 unlimited, 11 none |
| pin_sel | input | 1 | After configuration: 1 routes the pin to tri-state, 0 to readback |
| start_frame | input | ADDR_W | First frame address of a readback |
| mem_rd_en | output | 1 | Frame memory read strobe |
| mem_rd_addr | output | ADDR_W | Frame memory read address |
| mem_rd_data | input | FRAME_W | Frame word, valid the cycle after the read edge |
| sdo | output | 1 | Serial readback data, idle high |
| gts_n | output | 1 | Active-low global tri-state control |

## Verification
The main stream is run from three different start addresses: frame 0, a middle frame, and the last frame. Each frame carries a distinct memory word, so a wrong address, a wrong bit order or a frame-count slip shows up as a bit mismatch. Interrupted requests separate the stop, restart and one-edge-glitch cases: only a properly armed restart may produce a fresh leading 0, and it must begin again at frame 0. Permission codes, host enable, the pin select and the configured flag are then varied while the pin is toggled. This tells apart a blocked path, where `sdo` stays high, from a single-use path that must serve exactly one request, including the case where an early-withdrawn request must not use up the allowance.

// File: rtl/cfgrb_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the serial configuration readback controller.
// Assumes: permission codes are fixed two-bit values decoded by cfgrb_permit.
package cfgrb_pkg;

    // Permission option codes
    localparam logic [1:0] PERM_NONE = 2'b00;
    localparam logic [1:0] PERM_ONCE = 2'b01;
    localparam logic [1:0] PERM_ANY  = 2'b10;
    localparam logic [1:0] PERM_RSVD = 2'b11;

    // Alignment pair sent ahead of each frame: bit 1 first (0), then bit 0 (1)
    localparam logic [1:0] SYNC_PAIR = 2'b01;

    // Number of high samples needed to re-arm a request
    localparam int ARM_EDGES = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'b00,
        SEQ_LEAD   = 2'b01,
        SEQ_STREAM = 2'b10
    } seq_state_e;

endpackage

// File: rtl/cfgrb_req_detect.sv
`timescale 1ns/1ps
// Request pin front end: decides pin ownership (readback or global tri-state),
// arms on ARM_EDGES consecutive high samples and flags a launch when an armed
// pin is sampled low with the readback path open. Also raises a stop request
// whenever the pin is high or the path is closed.
// Assumes: rd_req_n is already synchronous to clk.
module cfgrb_req_detect
    import cfgrb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic cfg_done,
    input  logic host_if_en,
    input  logic pin_sel,
    output logic start_req,
    output logic abort_req,
    output logic path_en,
    output logic gts_n
);

    localparam int CNT_W = $clog2(ARM_EDGES + 1);
    localparam logic [CNT_W-1:0] ARM_MAX = CNT_W'(ARM_EDGES);

    logic [CNT_W-1:0] high_cnt;
    logic             armed;

    // Purpose: count consecutive high samples of the pin, saturating at ARM_MAX
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_cnt <= '0;
        end else if (req_n) begin
            if (high_cnt != ARM_MAX) begin
                high_cnt <= high_cnt + 1'b1;
            end
        end else begin
            high_cnt <= '0;
        end
    end

    // Purpose: derive pin ownership, launch and stop conditions
    always_comb begin
        path_en   = cfg_done && !host_if_en && !pin_sel;
        armed     = (high_cnt == ARM_MAX);
        start_req = armed && !req_n && path_en;
        abort_req = req_n || !path_en;
        gts_n     = (!cfg_done || pin_sel) ? req_n : 1'b1;
    end

    // R1
    launch_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> ($past(req_n) && $past(req_n, 2)));

    // R10
    gts_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_done || pin_sel) |-> !start_req);

endmodule

// File: rtl/cfgrb_permit.sv
`timescale 1ns/1ps
// Readback permission tracker: decodes the permission option and remembers
// whether the single allowed readback has been used.
// Assumes: consume pulses for one cycle per readback, on its first alignment bit.
module cfgrb_permit
    import cfgrb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] perm_opt,
    input  logic       consume,
    output logic       allow
);

    logic used_q;

    // Purpose: latch that a readback has been started since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= 1'b0;
        end else if (consume) begin
            used_q <= 1'b1;
        end
    end

    // Purpose: decode the permission option into a launch allowance
    always_comb begin
        case (perm_opt)
            PERM_ONCE: allow = !used_q;
            PERM_ANY:  allow = 1'b1;
            PERM_NONE: allow = 1'b0;
            default:   allow = 1'b0;
        endcase
    end

    // R7
    once_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && perm_opt == PERM_ONCE) |=> (perm_opt != PERM_ONCE || !allow));

endmodule

// File: rtl/cfgrb_frame_seq.sv
`timescale 1ns/1ps
// Frame sequencer: waits LATENCY edges after a launch, then for each frame
// issues one memory read, sends the 0/1 alignment pair and shifts the frame
// word out MSB first. Frames run back to back up to the last one; the output
// idles high.
// Assumes: LATENCY >= 2 and FRAME_W >= 2; memory data is valid the cycle after
// the edge that samples mem_rd_en.
module cfgrb_frame_seq
    import cfgrb_pkg::*;
#(
    parameter int FRAME_W    = 32,
    parameter int NUM_FRAMES = 6,
    parameter int LATENCY    = 4,
    parameter int ADDR_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic               abort_req,
    input  logic               allow,
    input  logic [ADDR_W-1:0]  start_frame,
    input  logic [FRAME_W-1:0] mem_rd_data,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    output logic               sdo,
    output logic               consume,
    output logic               busy
);

    localparam int BITS_PER_FRAME = FRAME_W + 2;
    localparam int IDX_W = $clog2(BITS_PER_FRAME + 1);
    localparam int LAT_W = (LATENCY > 2) ? $clog2(LATENCY) : 1;
    localparam logic [IDX_W-1:0]  IDX_PAIR_HI = IDX_W'(1);
    localparam logic [IDX_W-1:0]  IDX_FIRST   = IDX_W'(2);
    localparam logic [IDX_W-1:0]  IDX_END     = IDX_W'(BITS_PER_FRAME);
    localparam logic [LAT_W-1:0]  LAT_LAST    = LAT_W'(LATENCY - 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR   = ADDR_W'(NUM_FRAMES - 1);

    seq_state_e         state_q;
    logic [LAT_W-1:0]   lat_cnt;
    logic [IDX_W-1:0]   bit_idx;
    logic [ADDR_W-1:0]  frame_q;
    logic [FRAME_W-1:0] shreg;
    logic               sdo_q;
    logic               rd_en_q;
    logic               launch;
    logic               lat_done;

    // Purpose: decode launch and end-of-lead-in conditions
    always_comb begin
        launch   = (state_q == SEQ_IDLE) && start_req && allow;
        lat_done = (state_q == SEQ_LEAD) && (lat_cnt == LAT_LAST);
        consume  = lat_done && !abort_req;
        busy     = (state_q != SEQ_IDLE);
    end

    // Purpose: run the lead-in, frame stepping and serial shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            lat_cnt <= '0;
            bit_idx <= '0;
            frame_q <= '0;
            shreg   <= '0;
            sdo_q   <= 1'b1;
            rd_en_q <= 1'b0;
        end else begin
            rd_en_q <= 1'b0;
            if (abort_req) begin
                state_q <= SEQ_IDLE;
                sdo_q   <= 1'b1;
            end else begin
                case (state_q)
                    SEQ_IDLE: begin
                        sdo_q <= 1'b1;
                        if (launch) begin
                            state_q <= SEQ_LEAD;
                            lat_cnt <= '0;
                            frame_q <= start_frame;
                        end
                    end
                    SEQ_LEAD: begin
                        if (lat_done) begin
                            state_q <= SEQ_STREAM;
                            sdo_q   <= SYNC_PAIR[1];
                            rd_en_q <= 1'b1;
                            bit_idx <= IDX_PAIR_HI;
                        end else begin
                            lat_cnt <= lat_cnt + 1'b1;
                        end
                    end
                    SEQ_STREAM: begin
                        if (bit_idx == IDX_PAIR_HI) begin
                            sdo_q   <= SYNC_PAIR[0];
                            bit_idx <= IDX_FIRST;
                        end else if (bit_idx == IDX_FIRST) begin
                            sdo_q   <= mem_rd_data[FRAME_W-1];
                            shreg   <= {mem_rd_data[FRAME_W-2:0], 1'b0};
                            bit_idx <= bit_idx + 1'b1;
                        end else if (bit_idx == IDX_END) begin
                            if (frame_q >= LAST_ADDR) begin
                                state_q <= SEQ_IDLE;
                                sdo_q   <= 1'b1;
                            end else begin
                                frame_q <= frame_q + 1'b1;
                                sdo_q   <= SYNC_PAIR[1];
                                rd_en_q <= 1'b1;
                                bit_idx <= IDX_PAIR_HI;
                            end
                        end else begin
                            sdo_q   <= shreg[FRAME_W-1];
                            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    default: begin
                        state_q <= SEQ_IDLE;
                        sdo_q   <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign sdo         = sdo_q;
    assign mem_rd_en   = rd_en_q;
    assign mem_rd_addr = frame_q;

    // R11
    rd_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R11
    rd_before_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_STREAM && bit_idx == IDX_FIRST) |-> $past(mem_rd_en));

    // R2
    pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_STREAM && bit_idx == IDX_FIRST) |-> (sdo && !$past(sdo)));

endmodule

// File: rtl/cfg_readback_ctrl.sv
`timescale 1ns/1ps
// Serial configuration readback controller (top). Connects the request pin
// front end, the permission tracker and the frame sequencer.
// Assumes: all inputs are synchronous to clk; the frame memory has one cycle
// of read latency.
module cfg_readback_ctrl
    import cfgrb_pkg::*;
#(
    parameter int FRAME_W    = 32,
    parameter int NUM_FRAMES = 6,
    parameter int LATENCY    = 4,
    parameter int ADDR_W     = $clog2(NUM_FRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req_n,
    input  logic               cfg_done,
    input  logic               host_if_en,
    input  logic [1:0]         perm_opt,
    input  logic               pin_sel,
    input  logic [ADDR_W-1:0]  start_frame,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic [FRAME_W-1:0] mem_rd_data,
    output logic               sdo,
    output logic               gts_n
);

    logic start_req;
    logic abort_req;
    logic path_en;
    logic allow;
    logic consume;
    logic busy;

    cfgrb_req_detect u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_n      (rd_req_n),
        .cfg_done   (cfg_done),
        .host_if_en (host_if_en),
        .pin_sel    (pin_sel),
        .start_req  (start_req),
        .abort_req  (abort_req),
        .path_en    (path_en),
        .gts_n      (gts_n)
    );

    cfgrb_permit u_permit (
        .clk      (clk),
        .rst_n    (rst_n),
        .perm_opt (perm_opt),
        .consume  (consume),
        .allow    (allow)
    );

    cfgrb_frame_seq #(
        .FRAME_W    (FRAME_W),
        .NUM_FRAMES (NUM_FRAMES),
        .LATENCY    (LATENCY),
        .ADDR_W     (ADDR_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .abort_req   (abort_req),
        .allow       (allow),
        .start_frame (start_frame),
        .mem_rd_data (mem_rd_data),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .sdo         (sdo),
        .consume     (consume),
        .busy        (busy)
    );

    // R4
    stop_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_n |=> sdo);

    // R9
    host_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_if_en |=> (sdo && !busy));

    // R10
    gts_pre_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (gts_n == rd_req_n));

    // R6
    prohibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((perm_opt == PERM_NONE || perm_opt == PERM_RSVD) && !busy) |=> !busy);

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (sdo && !mem_rd_en));

    // R9
    path_closed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !path_en |=> !busy);

endmodule

// File: tb/cfg_readback_ctrl_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected serial bits and read
// addresses; a monitor pops and compares them two ns after each rising edge.
module cfg_readback_ctrl_test;

    localparam int NF  = 6;
    localparam int FW  = 32;
    localparam int LAT = 4;
    localparam int AW  = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rd_req_n;
    logic          cfg_done;
    logic          host_if_en;
    logic [1:0]    perm_opt;
    logic          pin_sel;
    logic [AW-1:0] start_frame;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [FW-1:0] mem_q;
    logic          sdo;
    logic          gts_n;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    bit    exp_q[$];
    string tag_q[$];
    int    addr_q[$];

    always #5 clk = ~clk;

    cfg_readback_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req_n    (rd_req_n),
        .cfg_done    (cfg_done),
        .host_if_en  (host_if_en),
        .perm_opt    (perm_opt),
        .pin_sel     (pin_sel),
        .start_frame (start_frame),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_q),
        .sdo         (sdo),
        .gts_n       (gts_n)
    );

    // Bench frame memory content, distinct per address
    function automatic logic [FW-1:0] frame_word(input int a);
        return (32'h9E37_79B9 * (a + 1)) ^ 32'h0F0F_1234;
    endfunction

    // Frame memory model with one cycle of read latency
    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_q <= frame_word(int'(mem_rd_addr));
    end

    // Monitor: compare serial output and read addresses against the queues
    always @(posedge clk) begin
        bit    v;
        string t;
        int    a;
        #2;
        if (exp_q.size() > 0) begin
            v = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (sdo !== v) begin
                errors++;
                $display("FAIL %s: sdo=%b expected %b at %0t", t, sdo, v, $time);
            end
        end
        if (mem_rd_en === 1'b1) begin
            checks++;
            if (addr_q.size() == 0) begin
                errors++;
                $display("FAIL R11: unexpected read addr=%0d expected none", mem_rd_addr);
            end else begin
                a = addr_q.pop_front();
                if (int'(mem_rd_addr) != a) begin
                    errors++;
                    $display("FAIL R11: read addr=%0d expected %0d", mem_rd_addr, a);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input bit v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic push_ones(input int n, input string t);
        for (int i = 0; i < n; i++) push(1'b1, t);
    endtask

    // Leading 0/1 pair plus the first n data bits of frame f, MSB first
    task automatic push_frame_bits(input int f, input int n, input string t);
        logic [FW-1:0] w;
        w = frame_word(f);
        addr_q.push_back(f);
        push(1'b0, "R2");
        push(1'b1, "R2");
        for (int b = FW - 1; b >= FW - n; b--) push(w[b], t);
    endtask

    // Full readback from frame first through the last frame, then idle high
    task automatic expect_readback(input int first, input string t);
        push_ones(LAT, "R1");
        for (int f = first; f < NF; f++) push_frame_bits(f, FW, t);
        push_ones(3, "R3");
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        @(negedge clk);
    endtask

    // Pin high across two rising edges
    task automatic arm();
        rd_req_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic request(input int first, input string t);
        start_frame = AW'(first);
        rd_req_n = 1'b0;
        expect_readback(first, t);
        drain();
    endtask

    task automatic request_blocked(input string t);
        rd_req_n = 1'b0;
        push_ones(LAT + 6, t);
        drain();
    endtask

    task automatic request_partial(input int n);
        start_frame = '0;
        rd_req_n = 1'b0;
        push_ones(LAT, "R1");
        push_frame_bits(0, n, "R2");
        drain();
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run not finished expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rd_req_n = 1'b1; cfg_done = 1'b0; host_if_en = 1'b0;
        perm_opt = 2'b10; pin_sel = 1'b0; start_frame = '0;
        repeat (3) @(negedge clk);
        chk("R12 sdo in reset", 32'(sdo), 32'd1);
        chk("R12 rd_en in reset", 32'(mem_rd_en), 32'd0);
        chk("R10 gts before config", 32'(gts_n), 32'd1);
        rst_n = 1'b1;
        arm();

        // R10: not configured, pin drives tri-state, no readback
        rd_req_n = 1'b0; #1;
        chk("R10 gts follows pin low pre-config", 32'(gts_n), 32'd0);
        push_ones(LAT + 6, "R10");
        drain();
        rd_req_n = 1'b1; #1;
        chk("R10 gts follows pin high pre-config", 32'(gts_n), 32'd1);

        // R10: configured, pin routed to tri-state
        cfg_done = 1'b1; pin_sel = 1'b1;
        arm();
        rd_req_n = 1'b0; #1;
        chk("R10 gts follows pin when selected", 32'(gts_n), 32'd0);
        push_ones(LAT + 6, "R10");
        drain();

        // R1/R2/R3: pin owns readback, full readback from frame 0
        pin_sel = 1'b0;
        arm();
        rd_req_n = 1'b0; #1;
        chk("R10 gts idle when pin owns readback", 32'(gts_n), 32'd1);
        @(negedge clk);
        arm();
        request(0, "R2");

        // R8: more readbacks, middle and last start frames
        arm();
        request(3, "R8");
        arm();
        request(NF - 1, "R3");

        // R4: stop mid-frame, output high at once
        arm();
        request_partial(10);
        rd_req_n = 1'b1;
        push_ones(3, "R4");
        drain();

        // R5: proper restart begins again at frame 0
        request(0, "R5");

        // R5: one-edge high pulse does not restart
        arm();
        request_partial(6);
        rd_req_n = 1'b1;
        push_ones(LAT + 9, "R5");
        @(negedge clk);
        rd_req_n = 1'b0;
        drain();

        // R9: host interface enable stops and blocks readback
        arm();
        request_partial(8);
        host_if_en = 1'b1;
        push_ones(3, "R9");
        drain();
        arm();
        request_blocked("R9");
        host_if_en = 1'b0;

        // R6: prohibit codes
        perm_opt = 2'b00;
        arm();
        request_blocked("R6");
        perm_opt = 2'b11;
        arm();
        request_blocked("R6");

        // R7: single readback; early withdrawal does not count
        rst_n = 1'b0;
        perm_opt = 2'b01;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        arm();
        rd_req_n = 1'b0;
        push_ones(2, "R7");
        drain();
        rd_req_n = 1'b1;
        push_ones(2, "R7");
        drain();
        request(0, "R7");
        arm();
        request_blocked("R7");
        arm();
        request_blocked("R7");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule